// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This block is a watchdog timer reached through a zero-wait-state APB slave port. A down-counter moves one step on every pulse of a tick-enable input that runs in the PCLK domain. When the count first steps down to zero, the block sets a pending-interrupt flag. If that flag has not been cleared by the time the count reaches zero again, the block latches a reset request and the counter stops. Software keeps the system alive by writing the clear register, which drops the flag and refills the count from the reload value. Separate enable bits decide whether the flag drives the interrupt pin and whether the latched request drives the reset pin.

A lock register guards every other register. Writing one particular 32-bit key opens the block, and writing any other value closes it again. An integration-test mode lets a register drive both output pins directly. A fixed table of identification bytes can be read back. A parameter builds a variant in which the control register freezes once the interrupt enable is set. In that variant the integration-test registers are not built.

Top module: `apb_wdog_two_stage`

## Requirements
- R1: After reset the control register, lock state, raw flag, reset status and test registers read 0. The reload value and the count (offsets 0x000 and 0x004) read 0xFFFFFFFF. The counter is running, so one tick leaves 0xFFFFFFFE. Both output pins are low.
- R2: A write to offset 0x000 loads both the reload value and the count with the written word and restarts the counter. Both offsets then read back that word.
- R3: Each tick while running lowers the count by one. Stepping from 1 to 0 is an expiry. A tick that finds the count at 0 reloads it from the reload value and is not an expiry.
- R4: An expiry while the raw flag (offset 0x010 bit 0) is 0 sets the flag. An expiry while the flag is 1 sets the reset status and stops the counter, after which ticks leave the count unchanged.
- R5: Any write to offset 0x00C clears the raw flag and reloads the count from the reload value. Offset 0x00C reads as 0.
- R6: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and any other value locks it. Offset 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to every other offset have no effect.
- R7: The interrupt pin equals the raw flag AND control bit 0. The reset pin equals the reset status AND control bit 1. Offset 0x014 reads the raw flag AND control bit 0. The reset status stays set until the block is reset.
- R8: While offset 0xF00 bit 0 is 1, the interrupt pin follows offset 0xF04 bit 1 and the reset pin follows offset 0xF04 bit 0. These two registers keep only those bits.
- R9: With STICKY_CTRL set, writes to offset 0x008 are ignored once control bit 0 is 1. Offsets 0xF00 and 0xF04 read 0, ignore writes and leave the pins on their normal logic.
- R10: Offsets 0xFD0 to 0xFFC read entries 0 to 11 of the ID_BYTES table, zero-extended. The default table is 04 00 00 00 24 B8 1B 00 0D F0 05 B1.
- R11: Unmapped offsets read 0, and writes to read-only offsets (0x004, 0x010, 0x014, the identification words) have no effect. PREADY is always 1 and PSLVERR always 0.
- R12: A write to 0x000 or 0x00C in the same cycle as a tick takes precedence, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| wdog_tick | input | 1 | One-cycle counter step enable |
| wdog_irq | output | 1 | Interrupt request |
| wdog_rst_req | output | 1 | Reset request |

## Verification
The assertions assume that wdog_tick is a synchronous pulse in the PCLK domain. They also assume that APB transfers follow the setup-then-access order and that address and data are held steady through the access cycle. The bench changes every input just after a falling clock edge. It always spends one setup cycle and one access cycle per transfer, and it raises the tick for exactly one rising edge. The collision case is the only place where a tick and a register write share the same edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Word addresses (byte offset >> 2); software decodes these positions.
  localparam int WA_W = 10;
  localparam logic [WA_W-1:0] WA_RELOAD = 10'h000;
  localparam logic [WA_W-1:0] WA_COUNT  = 10'h001;
  localparam logic [WA_W-1:0] WA_CTRL   = 10'h002;
  localparam logic [WA_W-1:0] WA_ICLR   = 10'h003;
  localparam logic [WA_W-1:0] WA_RAW    = 10'h004;
  localparam logic [WA_W-1:0] WA_MSK    = 10'h005;
  localparam logic [WA_W-1:0] WA_LOCK   = 10'h300;
  localparam logic [WA_W-1:0] WA_TCTL   = 10'h3C0;
  localparam logic [WA_W-1:0] WA_TOUT   = 10'h3C1;

  localparam int ID_COUNT = 12;
  localparam logic [5:0] ID_PAGE  = 6'h3F;
  localparam logic [3:0] ID_FIRST = 4'd4;

  typedef struct packed {
    logic rst_en;   // bit 1
    logic irq_en;   // bit 0
  } ctrl_t;

  function automatic logic gate(input logic flag, input logic en);
    return flag & en;
  endfunction

  function automatic logic in_id_window(input logic [WA_W-1:0] wa);
    return (wa[9:4] == ID_PAGE) && (wa[3:0] >= ID_FIRST);
  endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_req,
  input  logic             stop_req,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] load_q,
  output logic             run_q,
  output logic             expire_ev
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic bus_pri;
  logic step;

  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - ONE;
  endfunction

  assign bus_pri   = load_we | reload_req;
  assign step      = tick & run_q & ~bus_pri;
  assign expire_ev = step & (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      load_q  <= '1;
      run_q   <= 1'b1;
    end else if (load_we) begin
      load_q  <= load_val;
      count_q <= load_val;
      run_q   <= 1'b1;
    end else if (reload_req) begin
      count_q <= load_q;
    end else if (step) begin
      count_q <= step_value(count_q, load_q);
      if (stop_req) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_ev,
  input  logic clr_req,
  output logic raw_q,
  output logic res_q,
  output logic stop_req
);

  assign stop_req = expire_ev & raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      if (clr_req)                  raw_q <= 1'b0;
      else if (expire_ev && !raw_q) raw_q <= 1'b1;
      if (stop_req)                 res_q <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_outsel.sv
module wdog_outsel
  import wdog_pkg::*;
(
  input  logic       raw_q,
  input  logic       res_q,
  input  ctrl_t      ctrl_q,
  input  logic       tmode_q,
  input  logic [1:0] tout_q,
  output logic       irq_norm,
  output logic       irq,
  output logic       rst_req
);

  logic rst_norm;

  assign irq_norm = gate(raw_q, ctrl_q.irq_en);
  assign rst_norm = gate(res_q, ctrl_q.rst_en);
  assign irq      = tmode_q ? tout_q[1] : irq_norm;
  assign rst_req  = tmode_q ? tout_q[0] : rst_norm;

endmodule

// File: rtl/apb_wdog_two_stage.sv
module apb_wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter logic [31:0] UNLOCK_KEY  = 32'h1ACCE551,
  parameter bit          STICKY_CTRL = 1'b0,
  parameter logic [ID_COUNT-1:0][7:0] ID_BYTES = {
    8'hB1, 8'h05, 8'hF0, 8'h0D,
    8'h00, 8'h1B, 8'hB8, 8'h24,
    8'h00, 8'h00, 8'h00, 8'h04}
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        wdog_tick,
  output logic        wdog_irq,
  output logic        wdog_rst_req
);

  localparam int PAD_W = 32 - CNT_W;

  logic [WA_W-1:0]  wa;
  logic             wr, wr_ok, rd;
  logic             lock_q;
  ctrl_t            ctrl_q;
  logic             ctrl_open;
  logic             tmode_q;
  logic [1:0]       tout_q;
  logic             load_we, clr_we, ctrl_we, lock_we, tctl_we, tout_we;
  logic             locked_load_wr;
  logic [CNT_W-1:0] count_q, load_q;
  logic             run_q, expire_ev, stop_req;
  logic             raw_q, res_q, irq_norm;
  logic [3:0]       id_idx;
  logic             unused_addr;

  assign unused_addr = &{1'b0, paddr[1:0]};

  assign wa    = paddr[11:2];
  assign wr    = psel & penable & pwrite;
  assign rd    = psel & ~pwrite;
  assign wr_ok = wr & ~lock_q;

  assign ctrl_open = STICKY_CTRL ? ~ctrl_q.irq_en : 1'b1;

  assign load_we        = wr_ok & (wa == WA_RELOAD);
  assign clr_we         = wr_ok & (wa == WA_ICLR);
  assign ctrl_we        = wr_ok & (wa == WA_CTRL) & ctrl_open;
  assign lock_we        = wr & (wa == WA_LOCK);
  assign tctl_we        = wr_ok & (wa == WA_TCTL);
  assign tout_we        = wr_ok & (wa == WA_TOUT);
  assign locked_load_wr = wr & lock_q & (wa == WA_RELOAD);

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      lock_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (lock_we) lock_q <= (pwdata != UNLOCK_KEY);
      if (ctrl_we) ctrl_q <= ctrl_t'(pwdata[1:0]);
    end
  end

  generate
    if (STICKY_CTRL) begin : g_no_test
      logic unused_test;
      assign unused_test = &{1'b0, tctl_we, tout_we};
      assign tmode_q = 1'b0;
      assign tout_q  = 2'b00;
    end else begin : g_test
      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          tmode_q <= 1'b0;
          tout_q  <= 2'b00;
        end else begin
          if (tctl_we) tmode_q <= pwdata[0];
          if (tout_we) tout_q  <= pwdata[1:0];
        end
      end
    end
  endgenerate

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (pclk),
    .rst_n      (presetn),
    .tick       (wdog_tick),
    .load_we    (load_we),
    .load_val   (pwdata[CNT_W-1:0]),
    .reload_req (clr_we),
    .stop_req   (stop_req),
    .count_q    (count_q),
    .load_q     (load_q),
    .run_q      (run_q),
    .expire_ev  (expire_ev)
  );

  wdog_status u_status (
    .clk       (pclk),
    .rst_n     (presetn),
    .expire_ev (expire_ev),
    .clr_req   (clr_we),
    .raw_q     (raw_q),
    .res_q     (res_q),
    .stop_req  (stop_req)
  );

  wdog_outsel u_outsel (
    .raw_q    (raw_q),
    .res_q    (res_q),
    .ctrl_q   (ctrl_q),
    .tmode_q  (tmode_q),
    .tout_q   (tout_q),
    .irq_norm (irq_norm),
    .irq      (wdog_irq),
    .rst_req  (wdog_rst_req)
  );

  assign id_idx = wa[3:0] - ID_FIRST;

  always_comb begin
    prdata = '0;
    if (rd) begin
      unique case (wa)
        WA_RELOAD: prdata = {{PAD_W{1'b0}}, load_q};
        WA_COUNT:  prdata = {{PAD_W{1'b0}}, count_q};
        WA_CTRL:   prdata = {30'b0, ctrl_q};
        WA_RAW:    prdata = {31'b0, raw_q};
        WA_MSK:    prdata = {31'b0, irq_norm};
        WA_LOCK:   prdata = {31'b0, lock_q};
        WA_TCTL:   prdata = {31'b0, tmode_q};
        WA_TOUT:   prdata = {30'b0, tout_q};
        default: begin
          if (in_id_window(wa)) prdata = {24'b0, ID_BYTES[id_idx]};
        end
      endcase
    end
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W       = 32,
  parameter bit STICKY_CTRL = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             expire_ev,
  input logic             raw_q,
  input logic             res_q,
  input logic             run_q,
  input logic             load_we,
  input logic             clr_we,
  input logic             locked_load_wr,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] count_q,
  input logic [1:0]       ctrl_q,
  input logic             pready,
  input logic             pslverr
);

  a_r4_first_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev && !raw_q |=> raw_q);

  a_r4_second_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev && raw_q |=> res_q && !run_q);

  a_r7_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    res_q |=> res_q);

  a_r5_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> !raw_q && count_q == $past(load_q));

  a_r6_locked_load: assert property (@(posedge clk) disable iff (!rst_n)
    locked_load_wr |=> $stable(load_q) && $stable(count_q) || $past(tick));

  a_r9_sticky_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    STICKY_CTRL && ctrl_q[0] |=> $stable(ctrl_q));

  a_r12_bus_priority: assert property (@(posedge clk) disable iff (!rst_n)
    tick && load_we |=> count_q == $past(load_val));

  a_r11_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

endmodule

bind apb_wdog_two_stage wdog_checker #(
  .CNT_W(CNT_W),
  .STICKY_CTRL(STICKY_CTRL)
) u_chk (
  .clk            (pclk),
  .rst_n          (presetn),
  .tick           (wdog_tick),
  .expire_ev      (expire_ev),
  .raw_q          (raw_q),
  .res_q          (res_q),
  .run_q          (run_q),
  .load_we        (load_we),
  .clr_we         (clr_we),
  .locked_load_wr (locked_load_wr),
  .load_val       (pwdata[CNT_W-1:0]),
  .load_q         (load_q),
  .count_q        (count_q),
  .ctrl_q         (ctrl_q),
  .pready         (pready),
  .pslverr        (pslverr)
);

// File: tb/tb_apb_wdog_two_stage.sv
module tb_apb_wdog_two_stage;

  localparam logic [31:0] KEY = 32'h1ACCE551;
  localparam logic [11:0] O_RELOAD = 12'h000, O_COUNT = 12'h004, O_CTRL = 12'h008,
                          O_ICLR = 12'h00C, O_RAW = 12'h010, O_MSK = 12'h014,
                          O_LOCK = 12'hC00, O_TCTL = 12'hF00, O_TOUT = 12'hF04;

  logic clk = 1'b0;
  logic presetn = 1'b0;
  logic psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic tick = 1'b0;
  logic [31:0] prdata_a, prdata_b;
  logic pready_a, pready_b, pslverr_a, pslverr_b;
  logic irq_a, irq_b, rst_a, rst_b;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  apb_wdog_two_stage dut (
    .pclk(clk), .presetn(presetn), .psel(psel_a), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a),
    .pslverr(pslverr_a), .wdog_tick(tick), .wdog_irq(irq_a), .wdog_rst_req(rst_a));

  apb_wdog_two_stage #(.STICKY_CTRL(1'b1)) dut_v (
    .pclk(clk), .presetn(presetn), .psel(psel_b), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b), .pready(pready_b),
    .pslverr(pslverr_b), .wdog_tick(tick), .wdog_irq(irq_b), .wdog_rst_req(rst_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input bit v, input logic [11:0] a, input logic [31:0] d,
                    input bit with_tick = 1'b0);
    psel_a = ~v; psel_b = v; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    tick = with_tick;
    @(negedge clk);
    tick = 1'b0; psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input bit v, input logic [11:0] a, output logic [31:0] d);
    psel_a = ~v; psel_b = v; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = v ? prdata_b : prdata_a;
    check("R11 pready", {31'b0, v ? pready_b : pready_a}, 32'd1);
    check("R11 pslverr", {31'b0, v ? pslverr_b : pslverr_a}, 32'd0);
    @(negedge clk);
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input bit v, input logic [11:0] a, input logic [31:0] exp,
                        input string tag);
    logic [31:0] d;
    rd(v, a, d);
    check(tag, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    presetn = 1'b0;
    @(negedge clk);
    presetn = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] id_ref(input int i);
    logic [7:0] b;
    case (i)
      0: b = 8'h04;  4: b = 8'h24;  5: b = 8'hB8;  6: b = 8'h1B;
      8: b = 8'h0D;  9: b = 8'hF0; 10: b = 8'h05; 11: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return {24'b0, b};
  endfunction

  task automatic t_reset_state();
    check("R1 irq low", {31'b0, irq_a}, 0);
    check("R1 rst low", {31'b0, rst_a}, 0);
    rd_chk(0, O_RELOAD, 32'hFFFFFFFF, "R1 reload");
    rd_chk(0, O_COUNT, 32'hFFFFFFFF, "R1 count");
    rd_chk(0, O_CTRL, 0, "R1 ctrl");
    rd_chk(0, O_LOCK, 0, "R1 lock");
    rd_chk(0, O_RAW, 0, "R1 raw");
    rd_chk(0, O_TCTL, 0, "R1 tctl");
    rd_chk(0, O_TOUT, 0, "R1 tout");
    ticks(1);
    rd_chk(0, O_COUNT, 32'hFFFFFFFE, "R1 running");
  endtask

  task automatic t_load_and_step();
    wr(0, O_RELOAD, 32'd5);
    rd_chk(0, O_RELOAD, 32'd5, "R2 reload");
    rd_chk(0, O_COUNT, 32'd5, "R2 count");
    ticks(2);
    rd_chk(0, O_COUNT, 32'd3, "R3 decrement");
  endtask

  task automatic t_two_stage();
    do_reset();
    wr(0, O_CTRL, 32'd3);
    wr(0, O_RELOAD, 32'd3);
    ticks(2);
    check("R3 no early expiry", {31'b0, irq_a}, 0);
    ticks(1);
    check("R4 first expiry irq", {31'b0, irq_a}, 1);
    check("R4 first expiry no rst", {31'b0, rst_a}, 0);
    rd_chk(0, O_RAW, 1, "R4 raw set");
    rd_chk(0, O_MSK, 1, "R7 masked");
    ticks(1);
    rd_chk(0, O_COUNT, 32'd3, "R3 reload at zero");
    check("R3 reload not expiry", {31'b0, rst_a}, 0);
    ticks(3);
    check("R4 second expiry rst", {31'b0, rst_a}, 1);
    ticks(2);
    rd_chk(0, O_COUNT, 32'd0, "R4 stopped");
    wr(0, O_ICLR, 32'hDEAD);
    check("R5 irq cleared", {31'b0, irq_a}, 0);
    check("R7 rst sticky", {31'b0, rst_a}, 1);
    rd_chk(0, O_RAW, 0, "R5 raw cleared");
    rd_chk(0, O_ICLR, 0, "R5 clr reads zero");
    ticks(1);
    rd_chk(0, O_COUNT, 32'd3, "R4 still stopped after clear");
  endtask

  task automatic t_masking();
    do_reset();
    wr(0, O_RELOAD, 32'd1);
    ticks(1);
    rd_chk(0, O_RAW, 1, "R7 raw without enable");
    rd_chk(0, O_MSK, 0, "R7 masked off");
    check("R7 irq masked", {31'b0, irq_a}, 0);
    wr(0, O_CTRL, 32'd1);
    check("R7 irq enabled", {31'b0, irq_a}, 1);
    rd_chk(0, O_MSK, 1, "R7 masked on");
    ticks(1); ticks(1);
    check("R7 rst gated by enable", {31'b0, rst_a}, 0);
    wr(0, O_CTRL, 32'd3);
    check("R7 rst enabled", {31'b0, rst_a}, 1);
  endtask

  task automatic t_lock();
    do_reset();
    wr(0, O_LOCK, 32'h0);
    rd_chk(0, O_LOCK, 1, "R6 locked");
    wr(0, O_RELOAD, 32'd7);
    rd_chk(0, O_RELOAD, 32'hFFFFFFFF, "R6 reload ignored");
    wr(0, O_CTRL, 32'd3);
    rd_chk(0, O_CTRL, 0, "R6 ctrl ignored");
    wr(0, O_LOCK, KEY ^ 32'h1);
    rd_chk(0, O_LOCK, 1, "R6 near key stays locked");
    wr(0, O_LOCK, KEY);
    rd_chk(0, O_LOCK, 0, "R6 unlocked");
    wr(0, O_RELOAD, 32'd7);
    rd_chk(0, O_COUNT, 32'd7, "R6 write after unlock");
  endtask

  task automatic t_test_mode();
    do_reset();
    wr(0, O_TCTL, 32'd1);
    wr(0, O_TOUT, 32'd2);
    check("R8 irq from bit1", {31'b0, irq_a}, 1);
    check("R8 rst off", {31'b0, rst_a}, 0);
    wr(0, O_TOUT, 32'hFFFF_FFFD);
    check("R8 irq off", {31'b0, irq_a}, 0);
    check("R8 rst from bit0", {31'b0, rst_a}, 1);
    rd_chk(0, O_TOUT, 32'd1, "R8 tout bits");
    rd_chk(0, O_TCTL, 32'd1, "R8 tctl bit");
    wr(0, O_TCTL, 32'd0);
    check("R8 back to normal", {30'b0, irq_a, rst_a}, 0);
  endtask

  task automatic t_ids();
    for (int i = 0; i < 12; i++)
      rd_chk(0, 12'hFD0 + 12'(4 * i), id_ref(i), $sformatf("R10 id %0d", i));
  endtask

  task automatic t_read_only();
    do_reset();
    wr(0, O_COUNT, 32'h55);
    rd_chk(0, O_COUNT, 32'hFFFFFFFF, "R11 count read-only");
    wr(0, O_RAW, 32'h1);
    rd_chk(0, O_RAW, 0, "R11 raw read-only");
    wr(0, O_MSK, 32'h1);
    rd_chk(0, O_MSK, 0, "R11 masked read-only");
    wr(0, 12'hFE0, 32'h77);
    rd_chk(0, 12'hFE0, 32'h24, "R11 id read-only");
    rd_chk(0, 12'h100, 0, "R11 unmapped");
    rd_chk(0, 12'h418, 0, "R11 unmapped 2");
  endtask

  task automatic t_collision();
    do_reset();
    wr(0, O_RELOAD, 32'd5);
    wr(0, O_RELOAD, 32'd9, 1'b1);
    rd_chk(0, O_COUNT, 32'd9, "R12 load beats tick");
    ticks(2);
    wr(0, O_ICLR, 32'd0, 1'b1);
    rd_chk(0, O_COUNT, 32'd9, "R12 clear beats tick");
  endtask

  task automatic t_variant();
    do_reset();
    rd_chk(1, O_CTRL, 0, "R9 variant reset");
    wr(1, O_CTRL, 32'd2);
    rd_chk(1, O_CTRL, 32'd2, "R9 writable before enable");
    wr(1, O_CTRL, 32'd1);
    rd_chk(1, O_CTRL, 32'd1, "R9 enable set");
    wr(1, O_CTRL, 32'd0);
    rd_chk(1, O_CTRL, 32'd1, "R9 frozen");
    wr(1, O_TCTL, 32'd1);
    wr(1, O_TOUT, 32'd3);
    rd_chk(1, O_TCTL, 0, "R9 tctl absent");
    rd_chk(1, O_TOUT, 0, "R9 tout absent");
    check("R9 pins normal", {30'b0, irq_b, rst_b}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_load_and_step();
    t_two_stage();
    t_masking();
    t_lock();
    t_test_mode();
    t_ids();
    t_read_only();
    t_collision();
    t_variant();
    finish_run();
  end

endmodule